// File: doc/BRIEF.md
# Serial Frame Transmitter with Break and Idle Insertion

This block turns bytes written by software into asynchronous serial frames on a single transmit line. A byte is written into a one-entry holding register. At the next frame boundary it moves into a shift register and is sent one bit per baud tick, with the least significant bit first. The bit clock comes from outside as a single-cycle `baud_tick` pulse, so the block does not divide any clock itself. Three level inputs control it: a transmitter enable, a send-break bit and an interrupt enable for transmission complete.

Two special frames can be placed between data words. Dropping the enable and raising it again while a frame is on the line queues an idle frame of all ones. A falling edge on the break bit queues a break frame: a run of zeros closed by one stop bit. While the break bit is held high, a break frame starts at every frame boundary. Queued special frames go out ahead of a pending data byte. Two flags report progress: holding register empty and transmission complete. The completion flag drives an interrupt line through its enable.

Top module: `serial_tx_core`

## Requirements
- R1: A data frame is a 0 start bit, then the DATA_W data bits with the least significant bit first, then a 1 stop bit. That is DATA_W+2 bit times. The line takes each new bit at the clock edge where `baud_tick` is sampled high. When a byte is held at the end of a frame, the next frame starts at that same tick, with no gap between frames.
- R2: When the enable rises from the disabled state, the first baud tick that follows is an idle delay bit with the line at 1. The earliest frame start is the second tick.
- R3: While the enable is 0 and no frame is on the line, `tx_o` stays 1 and a written byte waits in the holding register. A frame already in progress when the enable drops is completed unchanged.
- R4: If the enable goes 0 and then 1 during a frame, an idle frame of DATA_W+2 ones follows that frame. It is sent before any held data byte.
- R5: A falling edge on `send_brk` queues one break frame. A break frame is DATA_W+2 zeros followed by one stop bit of 1. The queued break is sent at the next frame boundary, ahead of any queued idle frame or held data byte.
- R6: While `send_brk` is 1, a break frame starts at every frame boundary where the transmitter is enabled.
- R7: After reset `txe_o` and `tc_o` are both 1. A write to the data register clears both flags from the next clock edge. `txe_o` is set at the tick where the held byte enters the shift register. `tc_o` is set at the tick where a frame ends when no frame starts and no byte is held.
- R8: `irq_o` is 1 exactly when `tc_o` and `tc_ie` are both 1. It follows them combinationally.
- R9: After reset, `tx_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| baud_tick | input | 1 | One-cycle pulse that marks each bit boundary |
| tx_en | input | 1 | Transmitter enable |
| send_brk | input | 1 | Send-break control bit |
| tc_ie | input | 1 | Interrupt enable for transmission complete |
| dr_wr | input | 1 | Data register write strobe |
| dr_wdata | input | DATA_W | Byte to be written |
| tx_o | output | 1 | Serial transmit line, idle high |
| txe_o | output | 1 | Holding register empty flag |
| tc_o | output | 1 | Transmission complete flag |
| irq_o | output | 1 | Transmission complete interrupt request |

## Verification
The line value for each bit is registered at the clock edge where the tick is seen, so that tick alone decides it. The bench waits for that edge and samples `tx_o` at the falling edge that follows. The flags change at the first clock edge after the write or the tick that causes them, and the bench reads them at the falling edge after that edge. `irq_o` has no register, so the bench checks it shortly after it changes `tc_ie`. The expected bit streams come from frame arithmetic that counts ticks from the stimulus. This covers the delay bit, frames sent back to back, and the idle and break frames in the order they are queued.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_DELAY = 2'd1,
    ST_READY = 2'd2,
    ST_BUSY  = 2'd3
  } stx_state_e;

  typedef enum logic [1:0] {
    FK_DATA = 2'd0,
    FK_IDLE = 2'd1,
    FK_BRK  = 2'd2
  } stx_kind_e;
endpackage

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  input  logic              tc_set,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_valid,
  output logic              txe,
  output logic              tc
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q, valid_d;
  logic              txe_q, txe_d;
  logic              tc_q, tc_d;

  always_comb begin
    valid_d = valid_q;
    txe_d   = txe_q;
    tc_d    = tc_q;
    if (take) begin
      valid_d = 1'b0;
      txe_d   = 1'b1;
    end
    if (tc_set) tc_d = 1'b1;
    if (wr) begin
      valid_d = 1'b1;
      txe_d   = 1'b0;
      tc_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      txe_q   <= 1'b1;
      tc_q    <= 1'b1;
    end else begin
      valid_q <= valid_d;
      txe_q   <= txe_d;
      tc_q    <= tc_d;
    end
  end

  // data register: clock enable on the write strobe only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  data_q <= '0;
    else if (wr) data_q <= wr_data;
  end

  assign hold_data  = data_q;
  assign hold_valid = valid_q;
  assign txe        = txe_q;
  assign tc         = tc_q;

  a_r7_write_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (!txe_q && !tc_q && valid_q));
  a_r7_take_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr) |=> (txe_q && !valid_q));
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  stx_kind_e         kind,
  input  logic [DATA_W-1:0] data,
  output logic              tx,
  output logic              busy,
  output logic              frame_end
);
  localparam int SH_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] LEN_WORD = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_BRK  = CNT_W'(DATA_W + 3);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [SH_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  assign frame_end = tick && busy_q && (cnt_q == CNT_ONE);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      busy_d = 1'b1;
      case (kind)
        FK_DATA: begin
          sh_d  = {1'b1, 1'b1, data, 1'b0};
          cnt_d = LEN_WORD;
        end
        FK_IDLE: begin
          sh_d  = '1;
          cnt_d = LEN_WORD;
        end
        default: begin
          sh_d  = {1'b1, {(DATA_W + 2){1'b0}}};
          cnt_d = LEN_BRK;
        end
      endcase
    end else if (tick && busy_q) begin
      if (cnt_q == CNT_ONE) begin
        busy_d = 1'b0;
        sh_d   = '1;
        cnt_d  = '0;
      end else begin
        sh_d  = {1'b1, sh_q[SH_W-1:1]};
        cnt_d = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign tx   = sh_q[0];
  assign busy = busy_q;

  a_r1_bit_holds_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(tx));
  a_r1_load_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q);
endmodule

// File: rtl/stx_ctrl.sv
module stx_ctrl
  import stx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      en,
  input  logic      brk,
  input  logic      hold_valid,
  input  logic      frame_end,
  output logic      load,
  output stx_kind_e kind,
  output logic      tc_set
);
  stx_state_e state_q, state_d;
  logic       en_d_q, brk_d_q;
  logic       idle_pend_q, idle_pend_d;
  logic       brk_pend_q, brk_pend_d;
  logic       en_rise, brk_fall, at_bound, want_brk;

  assign en_rise  = en && !en_d_q;
  assign brk_fall = !brk && brk_d_q;
  assign want_brk = brk || brk_pend_q;
  assign at_bound = tick && en && ((state_q == ST_READY) || frame_end);
  assign load     = at_bound && (want_brk || idle_pend_q || hold_valid);
  assign tc_set   = frame_end && !load && !hold_valid;

  always_comb begin
    if (want_brk)         kind = FK_BRK;
    else if (idle_pend_q) kind = FK_IDLE;
    else                  kind = FK_DATA;
  end

  always_comb begin
    idle_pend_d = idle_pend_q;
    brk_pend_d  = brk_pend_q;
    if (load && (kind == FK_IDLE))       idle_pend_d = 1'b0;
    if (en_rise && (state_q == ST_BUSY)) idle_pend_d = 1'b1;
    if (load && (kind == FK_BRK))        brk_pend_d  = 1'b0;
    if (brk_fall)                        brk_pend_d  = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:   if (en) state_d = ST_DELAY;
      ST_DELAY: begin
        if (!en)       state_d = ST_OFF;
        else if (tick) state_d = ST_READY;
      end
      ST_READY: begin
        if (!en)       state_d = ST_OFF;
        else if (load) state_d = ST_BUSY;
      end
      default: begin
        if (frame_end) begin
          if (load)    state_d = ST_BUSY;
          else if (en) state_d = ST_READY;
          else         state_d = ST_OFF;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_OFF;
      en_d_q      <= 1'b0;
      brk_d_q     <= 1'b0;
      idle_pend_q <= 1'b0;
      brk_pend_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      en_d_q      <= en;
      brk_d_q     <= brk;
      idle_pend_q <= idle_pend_d;
      brk_pend_q  <= brk_pend_d;
    end
  end

  a_r2_no_start_in_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DELAY) |-> !load);
  a_r3_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF) |-> !load);
  a_r4_idle_queued_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && (state_q == ST_BUSY)) |=> idle_pend_q);
endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              send_brk,
  input  logic              tc_ie,
  input  logic              dr_wr,
  input  logic [DATA_W-1:0] dr_wdata,
  output logic              tx_o,
  output logic              txe_o,
  output logic              tc_o,
  output logic              irq_o
);
  logic [1:0]        rs_q;
  logic              rst_n_int;
  logic              load_s, frame_end_s, busy_s, tc_set_s, hold_valid_s;
  stx_kind_e         kind_s;
  logic [DATA_W-1:0] hold_data_s;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_int = rs_q[1];

  stx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick       (baud_tick),
    .en         (tx_en),
    .brk        (send_brk),
    .hold_valid (hold_valid_s),
    .frame_end  (frame_end_s),
    .load       (load_s),
    .kind       (kind_s),
    .tc_set     (tc_set_s)
  );

  stx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr         (dr_wr),
    .wr_data    (dr_wdata),
    .take       (load_s && (kind_s == FK_DATA)),
    .tc_set     (tc_set_s),
    .hold_data  (hold_data_s),
    .hold_valid (hold_valid_s),
    .txe        (txe_o),
    .tc         (tc_o)
  );

  stx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (baud_tick),
    .load      (load_s),
    .kind      (kind_s),
    .data      (hold_data_s),
    .tx        (tx_o),
    .busy      (busy_s),
    .frame_end (frame_end_s)
  );

  assign irq_o = tc_o && tc_ie;

  a_r3_line_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!tx_en && !busy_s) |-> tx_o);
  a_r1_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_s && (kind_s == FK_DATA)) |=> !tx_o);
  a_r6_break_drives_low: assert property (@(posedge clk) disable iff (!rst_n_int)
    (load_s && send_brk) |=> !tx_o);
  a_r7_complete_sets_flag: assert property (@(posedge clk) disable iff (!rst_n_int)
    (frame_end_s && !load_s && !hold_valid_s && !dr_wr) |=> tc_o);
endmodule

// File: tb/serial_tx_core_tb.sv
module serial_tx_core_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int NB     = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              baud_tick = 1'b0;
  logic [1:0]        tcnt = 2'd0;
  logic              tx_en, send_brk, tc_ie, dr_wr;
  logic [DATA_W-1:0] dr_wdata;
  logic              tx_o, txe_o, tc_o, irq_o;

  int   n_run  = 0;
  int   n_fail = 0;
  logic log_q [0:127];
  int   nlog = 0;

  serial_tx_core #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .send_brk(send_brk), .tc_ie(tc_ie), .dr_wr(dr_wr), .dr_wdata(dr_wdata),
    .tx_o(tx_o), .txe_o(txe_o), .tc_o(tc_o), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // one tick every fourth cycle
  always @(negedge clk) begin
    tcnt      <= tcnt + 2'd1;
    baud_tick <= (tcnt == 2'd2);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step_tick();
    forever begin
      @(posedge clk);
      if (baud_tick) break;
    end
    @(negedge clk);
    log_q[nlog] = tx_o;
    nlog++;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step_tick();
  endtask

  task automatic wr_byte(input logic [7:0] b);
    dr_wdata = b;
    dr_wr    = 1'b1;
    @(negedge clk);
    dr_wr    = 1'b0;
  endtask

  task automatic chk_frame(input int base, input logic [7:0] b, input string req);
    logic [9:0] got, exp;
    exp = {1'b1, b, 1'b0};
    for (int j = 0; j < 10; j++) got[j] = log_q[base + j];
    chk(got == exp, req, got, exp);
  endtask

  task automatic chk_run(input int base, input int len, input logic v, input string req);
    int cnt;
    cnt = 0;
    for (int j = 0; j < len; j++) if (log_q[base + j] == v) cnt++;
    chk(cnt == len, req, cnt, len);
  endtask

  function automatic logic [7:0] pat(input int k);
    if (k == 0)      return 8'h00;
    else if (k == 1) return 8'hFF;
    else             return 8'(k * 37) ^ 8'h5A;
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0; send_brk = 1'b0; tc_ie = 1'b0;
    dr_wr = 1'b0; dr_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 / R7 / R8 reset state
    chk(tx_o == 1'b1, "R9 idle after reset", tx_o, 1);
    chk(txe_o == 1'b1 && tc_o == 1'b1, "R7 reset flags", {txe_o, tc_o}, 3);
    chk(irq_o == 1'b0, "R8 irq masked", irq_o, 0);
    tc_ie = 1'b1; #1;
    chk(irq_o == 1'b1, "R8 irq enabled", irq_o, 1);

    // R3: disabled, byte held, line idle
    step_tick();
    wr_byte(8'hA7);
    chk(txe_o == 1'b0 && tc_o == 1'b0, "R7 write clears flags", {txe_o, tc_o}, 0);
    nlog = 0;
    steps(12);
    chk_run(0, 12, 1'b1, "R3 idle while disabled");

    // R2: enable gives one delay bit, then the held byte goes out
    nlog = 0;
    tx_en = 1'b1;
    steps(12);
    chk(log_q[0] == 1'b1, "R2 delay bit", log_q[0], 1);
    chk_frame(1, 8'hA7, "R1 frame after delay");
    chk(log_q[11] == 1'b1, "R1 idle after frame", log_q[11], 1);
    chk(tc_o == 1'b1 && txe_o == 1'b1, "R7 complete after frame", {txe_o, tc_o}, 3);

    // R1 sweep, frames back to back
    nlog = 0;
    wr_byte(pat(0));
    for (int k = 0; k < NB; k++) begin
      step_tick();
      chk(txe_o == 1'b1, "R7 empty at load", txe_o, 1);
      if (k < NB - 1) wr_byte(pat(k + 1));
      steps(9);
      if (k < NB - 1) chk(tc_o == 1'b0, "R7 no complete mid stream", tc_o, 0);
    end
    step_tick();
    for (int k = 0; k < NB; k++) chk_frame(10 * k, pat(k), "R1 back-to-back frame");
    chk(log_q[10 * NB] == 1'b1, "R1 idle after stream", log_q[10 * NB], 1);
    chk(tc_o == 1'b1, "R7 complete after stream", tc_o, 1);

    // R4: enable toggle queues an idle frame ahead of the held byte
    nlog = 0;
    wr_byte(8'h3C);
    step_tick();
    tx_en = 1'b0;
    @(negedge clk);
    tx_en = 1'b1;
    wr_byte(8'hC3);
    steps(30);
    chk_frame(0, 8'h3C, "R3 frame survives enable toggle");
    chk_run(10, 10, 1'b1, "R4 idle frame ones");
    chk_frame(20, 8'hC3, "R4 data after idle frame");
    chk(log_q[30] == 1'b1, "R4 idle at end", log_q[30], 1);

    // R5: break pulse queues one break ahead of the held byte
    nlog = 0;
    wr_byte(8'h96);
    step_tick();
    send_brk = 1'b1;
    wr_byte(8'h69);
    send_brk = 1'b0;
    steps(31);
    chk_frame(0, 8'h96, "R5 current frame first");
    chk_run(10, 10, 1'b0, "R5 break zeros");
    chk(log_q[20] == 1'b1, "R5 break stop bit", log_q[20], 1);
    chk_frame(21, 8'h69, "R5 data after break");
    chk(log_q[31] == 1'b1, "R5 idle at end", log_q[31], 1);

    // R6: held break repeats at each boundary, release queues one more
    nlog = 0;
    send_brk = 1'b1;
    steps(13);
    send_brk = 1'b0;
    steps(21);
    for (int f = 0; f < 3; f++) begin
      chk_run(11 * f, 10, 1'b0, "R6 break zeros");
      chk(log_q[11 * f + 10] == 1'b1, "R6 break stop bit", log_q[11 * f + 10], 1);
    end
    chk(log_q[33] == 1'b1, "R6 idle after breaks", log_q[33], 1);
    chk(tc_o == 1'b1, "R7 complete after breaks", tc_o, 1);

    // R3: disabling mid-frame completes the frame, later bytes wait
    nlog = 0;
    wr_byte(8'hE1);
    step_tick();
    tx_en = 1'b0;
    steps(11);
    chk_frame(0, 8'hE1, "R3 frame completes after disable");
    chk_run(10, 2, 1'b1, "R3 idle after disable");
    chk(tc_o == 1'b1, "R7 complete after disable", tc_o, 1);
    wr_byte(8'h7E);
    nlog = 0;
    steps(12);
    chk_run(0, 12, 1'b1, "R3 held byte not sent");
    chk(txe_o == 1'b0, "R3 byte still held", txe_o, 0);
    chk(irq_o == 1'b0, "R8 irq low with flag clear", irq_o, 0);

    nlog = 0;
    tx_en = 1'b1;
    steps(12);
    chk(log_q[0] == 1'b1, "R2 delay bit again", log_q[0], 1);
    chk_frame(1, 8'h7E, "R1 held byte after re-enable");
    tc_ie = 1'b0; #1;
    chk(irq_o == 1'b0, "R8 irq masked with flag set", irq_o, 0);
    tc_ie = 1'b1; #1;
    chk(irq_o == 1'b1, "R8 irq raised", irq_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule